// File: doc/BRIEF.md
# CAN Bus Rejoin Sequencer

This block decides when a CAN protocol controller may leave its offline state and take part in bus traffic again. It holds the reset-mode flag, remembers why that flag was last raised, and counts bus-idle events, each being a run of eleven recessive bits, on the sampled receive stream. Reset mode is entered by a hardware reset, by the CPU writing the flag to one, or by a bus-off event from error management.

Once the CPU writes the flag back to zero, the block starts counting idle events. After a hardware or CPU reset one event is enough to go bus-on. After a bus-off the controller must see 128 events. The count so far can be read on a status output, so software can follow the recovery. Bit timing, error counting and frame decoding are handled elsewhere. The block only sees a sample strobe and the sampled bit.

Top module: `can_rejoin_seq`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `reset_mode_o` is 1, `bus_on_o` is 0, `recov_cnt_o` is 0 and the recorded cause is a software cause (needing one event).
- R2: `bus_off_evt` high at an edge sets `reset_mode_o` to 1, clears `bus_on_o` and `recov_cnt_o`, and records the bus-off cause (needing 128 events). It takes priority over a CPU write in the same cycle.
- R3: `mode_wr_en` high writes `mode_wr_val` into the reset-mode flag at that edge. Writing 1 records the software cause.
- R4: An idle event is 11 consecutive samples with `rx_bit` = 1 (recessive), each taken when `sample_stb` = 1. A sample with `rx_bit` = 0 (dominant) restarts the run. After a completed run the next run starts from zero, so back-to-back runs each count. Cycles with `sample_stb` = 0 have no effect.
- R5: With the software cause recorded, `bus_on_o` rises after one idle event that follows the clearing of reset mode.
- R6: With the bus-off cause recorded, `bus_on_o` rises only on the 128th idle event. It stays low after 127 events.
- R7: While reset mode is 1, samples are ignored: the run and `recov_cnt_o` stay at 0 and `bus_on_o` stays 0.
- R8: A CPU write of 1 during bus-off recovery replaces the recorded cause, so the next recovery needs one event.
- R9: `recov_cnt_o` (8 bits) counts idle events since reset mode was cleared. It holds its final value (1 or 128) while bus-on.
- R10: `bus_on_o` and `recov_cnt_o` change at the same clock edge that samples the eleventh recessive bit of the completing run. `bus_on_o` is never 1 while `reset_mode_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| mode_wr_en | input | 1 | CPU write strobe for the reset-mode flag |
| mode_wr_val | input | 1 | Value written to the reset-mode flag |
| bus_off_evt | input | 1 | Bus-off entry pulse from error management |
| sample_stb | input | 1 | Sample-point strobe |
| rx_bit | input | 1 | Sampled bus bit, 1 = recessive |
| reset_mode_o | output | 1 | Reset-mode flag |
| bus_on_o | output | 1 | Controller may take part in bus traffic |
| recov_cnt_o | output | 8 | Idle events counted in the current recovery |

## Verification
The idle detector is driven with clean runs of exactly ten and eleven recessive samples, with runs broken by a single dominant sample, with back-to-back runs, and with gaps without a strobe placed inside runs. These patterns separate off-by-one run lengths, a run counter that fails to restart, and a counter that reacts to cycles without a strobe. The recovery count is tested against both causes, at 127 and 128 events after a bus-off and at one event after a CPU reset. A CPU write during bus-off recovery and a bus-off coinciding with a CPU write check that the cause and the priority are recorded correctly. A seeded random phase then mixes strobes, mostly recessive bits, rare bus-off pulses and CPU writes, and compares every cycle against a bench model.

// File: rtl/can_rejoin_pkg.sv
package can_rejoin_pkg;
  typedef enum logic {
    CAUSE_SOFT   = 1'b0,
    CAUSE_BUSOFF = 1'b1
  } rst_cause_e;
endpackage

// File: rtl/idle_run_detect.sv
module idle_run_detect #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic stb,
  input  logic rx,
  output logic idle_pulse
);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] LAST = RW'(RUN_LEN - 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      run_q <= '0;
    end else if (stb) begin
      if (!rx)              run_q <= '0;
      else if (run_q == LAST) run_q <= '0;
      else                  run_q <= run_q + 1'b1;
    end
  end

  assign idle_pulse = !clear && stb && rx && (run_q == LAST);

  a_r4_run_bound: assert property (@(posedge clk) disable iff (rst)
    run_q < RW'(RUN_LEN));
  a_r4_dominant_restarts: assert property (@(posedge clk) disable iff (rst)
    (stb && !rx) |=> (run_q == '0));
  a_r7_clear_holds_run: assert property (@(posedge clk) disable iff (rst)
    clear |=> (run_q == '0));
endmodule

// File: rtl/rejoin_ctrl.sv
module rejoin_ctrl
  import can_rejoin_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SOFT_NEED   = 1,
  parameter int BUSOFF_NEED = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_val,
  input  logic             bus_off,
  output logic             mode_q,
  output logic             enter,
  output logic [CNT_W-1:0] need
);
  rst_cause_e cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= 1'b1;
      cause_q <= CAUSE_SOFT;
    end else if (bus_off) begin
      mode_q  <= 1'b1;
      cause_q <= CAUSE_BUSOFF;
    end else if (wr_en) begin
      mode_q <= wr_val;
      if (wr_val) cause_q <= CAUSE_SOFT;
    end
  end

  assign enter = bus_off || (wr_en && wr_val);
  assign need  = (cause_q == CAUSE_BUSOFF) ? CNT_W'(BUSOFF_NEED) : CNT_W'(SOFT_NEED);

  a_r1_hw_reset: assert property (@(posedge clk)
    rst |=> (mode_q && cause_q == CAUSE_SOFT));
  a_r2_busoff_enters: assert property (@(posedge clk) disable iff (rst)
    bus_off |=> (mode_q && cause_q == CAUSE_BUSOFF));
  a_r3_write_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_val && !bus_off) |=> !mode_q);
  a_r8_cpu_cause: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_val && !bus_off) |=> (mode_q && cause_q == CAUSE_SOFT));
endmodule

// File: rtl/rejoin_counter.sv
module rejoin_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             idle_pulse,
  input  logic [CNT_W-1:0] need,
  output logic [CNT_W-1:0] cnt_q,
  output logic             bus_on_q
);
  logic [CNT_W-1:0] cnt_nx;
  assign cnt_nx = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt_q    <= '0;
      bus_on_q <= 1'b0;
    end else if (idle_pulse && !bus_on_q) begin
      cnt_q <= cnt_nx;
      if (cnt_nx == need) bus_on_q <= 1'b1;
    end
  end

  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= need);
  a_r6_rise_at_need: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_on_q) |-> (cnt_q == need));
  a_r9_hold_when_on: assert property (@(posedge clk) disable iff (rst)
    (bus_on_q && !hold) |=> $stable(cnt_q));
  a_r7_zero_in_hold: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt_q == '0 && !bus_on_q));
endmodule

// File: rtl/can_rejoin_seq.sv
module can_rejoin_seq #(
  parameter int RUN_LEN     = 11,
  parameter int CNT_W       = 8,
  parameter int SOFT_NEED   = 1,
  parameter int BUSOFF_NEED = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr_en,
  input  logic             mode_wr_val,
  input  logic             bus_off_evt,
  input  logic             sample_stb,
  input  logic             rx_bit,
  output logic             reset_mode_o,
  output logic             bus_on_o,
  output logic [CNT_W-1:0] recov_cnt_o
);
  logic             mode_q;
  logic             enter;
  logic             hold;
  logic             idle_pulse;
  logic [CNT_W-1:0] need;

  rejoin_ctrl #(
    .CNT_W(CNT_W), .SOFT_NEED(SOFT_NEED), .BUSOFF_NEED(BUSOFF_NEED)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(mode_wr_en), .wr_val(mode_wr_val),
    .bus_off(bus_off_evt), .mode_q(mode_q), .enter(enter), .need(need)
  );

  assign hold = mode_q || enter;

  idle_run_detect #(.RUN_LEN(RUN_LEN)) u_idle (
    .clk(clk), .rst(rst), .clear(hold), .stb(sample_stb), .rx(rx_bit),
    .idle_pulse(idle_pulse)
  );

  rejoin_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .hold(hold), .idle_pulse(idle_pulse), .need(need),
    .cnt_q(recov_cnt_o), .bus_on_q(bus_on_o)
  );

  assign reset_mode_o = mode_q;

  a_r10_on_excludes_reset: assert property (@(posedge clk) disable iff (rst)
    bus_on_o |-> !reset_mode_o);
  a_r10_rise_needs_sample: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_on_o) |-> $past(sample_stb && rx_bit));
endmodule

// File: tb/test_can_rejoin_seq.sv
`timescale 1ns/1ps
module test_can_rejoin_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_wr_en = 1'b0, mode_wr_val = 1'b0, bus_off_evt = 1'b0;
  logic sample_stb = 1'b0, rx_bit = 1'b1;
  logic reset_mode_o, bus_on_o;
  logic [7:0] recov_cnt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  bit       m_mode = 1, m_cause = 0, m_on = 0;
  int       m_run = 0;
  int       m_cnt = 0;

  always #2.5 clk = ~clk;

  can_rejoin_seq i_can_rejoin_seq (
    .clk(clk), .rst(rst), .mode_wr_en(mode_wr_en), .mode_wr_val(mode_wr_val),
    .bus_off_evt(bus_off_evt), .sample_stb(sample_stb), .rx_bit(rx_bit),
    .reset_mode_o(reset_mode_o), .bus_on_o(bus_on_o), .recov_cnt_o(recov_cnt_o)
  );

  function automatic int need_for(bit cause);
    return cause ? 128 : 1;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(bit r, bit we, bit wv, bit bo, bit stb, bit rx, string tag);
    bit hold, pulse;
    rst = r; mode_wr_en = we; mode_wr_val = wv; bus_off_evt = bo;
    sample_stb = stb; rx_bit = rx;
    @(posedge clk);
    if (r) begin
      m_mode = 1; m_cause = 0; m_run = 0; m_cnt = 0; m_on = 0;
    end else begin
      hold  = m_mode || bo || (we && wv);
      pulse = !hold && stb && rx && (m_run == 10);
      if (hold) m_run = 0;
      else if (stb) m_run = (!rx || m_run == 10) ? 0 : m_run + 1;
      if (hold) begin
        m_cnt = 0; m_on = 0;
      end else if (pulse && !m_on) begin
        m_cnt++;
        if (m_cnt == need_for(m_cause)) m_on = 1;
      end
      if (bo) begin m_mode = 1; m_cause = 1; end
      else if (we) begin m_mode = wv; if (wv) m_cause = 0; end
    end
    @(negedge clk);
    chk(tag, "reset_mode", int'(reset_mode_o), int'(m_mode));
    chk(tag, "bus_on", int'(bus_on_o), int'(m_on));
    chk(tag, "recov_cnt", int'(recov_cnt_o), m_cnt);
  endtask

  task automatic samples(int n, bit rx, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, rx, tag);
  endtask

  task automatic idle_runs(int n, string tag);
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 11; i++) begin
        step(0, 0, 0, 0, 1, 1, tag);
        if (i == 4) step(0, 0, 0, 0, 0, 0, tag); // no strobe: ignored (R4)
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // R1 reset state
    step(1, 0, 0, 0, 1, 1, "R1");
    step(1, 0, 0, 0, 1, 1, "R1");
    chk("R1", "reset_mode literal", int'(reset_mode_o), 1);
    chk("R1", "bus_on literal", int'(bus_on_o), 0);
    // R7 samples while in reset mode are ignored
    samples(15, 1, "R7");
    chk("R7", "cnt in reset mode", int'(recov_cnt_o), 0);
    // R3 clear reset mode, R4 ten recessive then dominant
    step(0, 1, 0, 0, 0, 1, "R3");
    chk("R3", "mode cleared", int'(reset_mode_o), 0);
    samples(10, 1, "R4");
    chk("R4", "ten recessive not idle", int'(bus_on_o), 0);
    samples(1, 0, "R4");
    samples(10, 1, "R4");
    chk("R4", "run restarted by dominant", int'(bus_on_o), 0);
    samples(1, 1, "R10");
    chk("R5", "bus on after one event", int'(bus_on_o), 1);
    chk("R9", "count one", int'(recov_cnt_o), 1);
    idle_runs(2, "R9");
    chk("R9", "count holds while on", int'(recov_cnt_o), 1);
    // R2 bus off
    step(0, 0, 0, 1, 1, 1, "R2");
    chk("R2", "bus off mode", int'(reset_mode_o), 1);
    chk("R2", "bus off clears on", int'(bus_on_o), 0);
    step(0, 1, 0, 0, 0, 1, "R3");
    idle_runs(127, "R6");
    chk("R6", "127 events not on", int'(bus_on_o), 0);
    chk("R9", "count 127", int'(recov_cnt_o), 127);
    idle_runs(1, "R6");
    chk("R6", "128 events on", int'(bus_on_o), 1);
    chk("R9", "count 128", int'(recov_cnt_o), 128);
    // R8 CPU reset during bus-off recovery
    step(0, 0, 0, 1, 0, 1, "R2");
    step(0, 1, 0, 0, 0, 1, "R8");
    idle_runs(5, "R8");
    step(0, 1, 1, 0, 0, 1, "R8");
    step(0, 1, 0, 0, 0, 1, "R8");
    idle_runs(1, "R8");
    chk("R8", "one event after cpu reset", int'(bus_on_o), 1);
    // R2 priority over CPU write of 0
    step(0, 1, 0, 1, 1, 1, "R2");
    chk("R2", "bus off beats write", int'(reset_mode_o), 1);
    step(0, 1, 0, 0, 0, 1, "R3");
    idle_runs(3, "R2");
    chk("R2", "bus off cause kept", int'(recov_cnt_o), 3);
    // random phase
    for (int c = 0; c < 6000; c++) begin
      bit bo, we, wv, stb, rx;
      bo  = ($urandom % 700) == 0;
      we  = ($urandom % 150) == 0;
      wv  = ($urandom % 3) == 0;
      stb = ($urandom % 4) != 0;
      rx  = ($urandom % 40) != 0;
      if (m_mode && ($urandom % 20) == 0) begin we = 1; wv = 0; end
      step(0, we, wv, bo, stb, rx, "R4");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule